// File: doc/BRIEF.md
# Manchester Line Decoder with Delayed Level Sampling

This block recovers serial data and a bit-rate clock from a Manchester-coded line. No separate clock is needed. The line is re-timed into the system clock domain and every level change is detected. A change that arrives while the block is idle is treated as the transition in the middle of a bit. It starts a hold-off timer of three quarters of a bit period.

When the timer runs out, the block samples the line level. That level belongs to the first half of the following bit, so it is the value of that bit. Boundary transitions between bits fall inside the hold-off window and are ignored. This is why the direction of each edge never has to be known. A recovered clock is formed by XORing the held bit with the re-timed line.

Decoded bits are packed most-significant first into a byte. A one-cycle strobe marks each completed byte. The sender must open each transfer with a 0 bit so that the first edge seen is a mid-bit edge. That bit is never captured. If the transfer opens with a 1, the block locks half a bit off and delivers inverted bits for as long as every bit boundary carries a transition.

Top module: `manchester_delay_decoder`

## Requirements
- R1: The serial input passes through two flip-flops before edge detection. A line change made just after clock edge 0 is seen by the detector after edge 2.
- R2: The hold-off delay is DLY = (3*BIT_CLKS+2)/4 clocks, which is three quarters of the bit period rounded to the nearest clock. The timer is loaded on edge 3 after a line change and the sample is taken on edge 3+DLY. This is 15 clocks for BIT_CLKS=16 and 11 clocks for BIT_CLKS=10.
- R3: A line change seen while the hold-off timer runs does not restart or extend the timer. The bit that is decoded is not affected by it.
- R4: When the timer expires, the re-timed line level is loaded into `bit_out`. `bit_out` changes at no other time.
- R5: `rec_clk` equals `bit_out` XOR the re-timed line. Whenever the line has been steady for two clocks, it equals `bit_out` XOR `line_in`.
- R6: The leading sync 0 bit is not captured. The first bit after it lands in `byte_out[7]`. A frame 0 followed by 00110100 yields 0x34.
- R7: After every eighth sample, `byte_valid` is high for exactly one clock and `byte_out` shows the completed byte. `byte_out` changes only in that cycle. Consecutive bytes come out in order.
- R8: A transfer that opens with a 1 followed only by 1 bits, starting from a low idle line, decodes as the complement. Nine 1 bits yield the byte 0x00.
- R9: If a line change reaches the detector in the same cycle the timer expires, the sample is taken and a new hold-off starts in that cycle.
- R10: After reset, `bit_out`, `rec_clk`, `byte_out` and `byte_valid` are all 0, and the bit count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Manchester-coded serial line, asynchronous, idle low |
| bit_out | output | 1 | Most recently decoded bit |
| rec_clk | output | 1 | Recovered bit clock |
| byte_out | output | BYTE_W | Last completed byte, MSB first |
| byte_valid | output | 1 | One-cycle strobe for a new byte |

## Verification
Two functions can meet in one cycle: the expiry of the hold-off timer, which captures a bit, and the detection of a new edge, which starts a delay. The bench provokes this by placing a second line change exactly DLY clocks after the first, so that its detection lands on the expiry cycle. It then adds a third change inside the new window. The result is judged by timing. `bit_out` must still be 0 one clock before edge 3+2*DLY and must be 1 right after it. If the coincident edge had been dropped, the third change would have started a delay instead, and the sample would arrive five clocks later.

// File: rtl/manchester_delay_decoder.sv
module manchester_delay_decoder #(
  parameter int BIT_CLKS = 16,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  output logic              bit_out,
  output logic              rec_clk,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_valid
);

  localparam int DLY = (3 * BIT_CLKS + 2) / 4;
  localparam int CW  = $clog2(DLY + 1);
  localparam int BCW = $clog2(BYTE_W);

  logic [1:0]        sync_q;
  logic              line_d;
  logic              busy;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BCW-1:0]    nbit;

  wire line_s   = sync_q[1];
  wire edge_hit = line_s ^ line_d;
  wire expire   = busy && (cnt == '0);
  wire start    = edge_hit && (!busy || expire);

  assign rec_clk = bit_out ^ line_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      line_d <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], line_in};
      line_d <= line_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(DLY - 1);
    end else if (expire) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_out    <= 1'b0;
      shreg      <= '0;
      nbit       <= '0;
      byte_out   <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (expire) begin
        bit_out <= line_s;
        shreg   <= {shreg[BYTE_W-2:0], line_s};
        if (nbit == BCW'(BYTE_W - 1)) begin
          nbit       <= '0;
          byte_out   <= {shreg[BYTE_W-2:0], line_s};
          byte_valid <= 1'b1;
        end else begin
          nbit <= nbit + 1'b1;
        end
      end
    end
  end

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && (cnt == CW'(DLY - 1)));

  // R3
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy && (cnt == CW'($past(cnt) - 1'b1)));

  // R4
  capture_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !expire |=> $stable(bit_out));

  // R7
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R7
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_out) |-> byte_valid);

endmodule

// File: tb/test_manchester_delay_decoder.sv
`timescale 1ns/100ps
module test_manchester_delay_decoder;

  localparam int A_BIT = 16;
  localparam int B_BIT = 10;
  localparam int A_DLY = (3 * A_BIT + 2) / 4;
  localparam int B_DLY = (3 * B_BIT + 2) / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b0;
  logic a_bit, a_rclk, a_valid, b_bit, b_rclk, b_valid;
  logic [7:0] a_byte, b_byte;

  int checks = 0;
  int errors = 0;
  logic [7:0] a_got [4];
  logic [7:0] b_got [4];
  int a_n = 0;
  int b_n = 0;
  logic a_prev_v = 1'b0;
  logic [2:0] lh = '0;

  always #2.5 clk = ~clk;

  manchester_delay_decoder #(.BIT_CLKS(A_BIT), .BYTE_W(8)) i_manchester_delay_decoder (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .bit_out(a_bit),
    .rec_clk(a_rclk), .byte_out(a_byte), .byte_valid(a_valid));

  manchester_delay_decoder #(.BIT_CLKS(B_BIT), .BYTE_W(8)) i_slow (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .bit_out(b_bit),
    .rec_clk(b_rclk), .byte_out(b_byte), .byte_valid(b_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (a_valid) begin
        chk(!a_prev_v, "R7 single-cycle strobe", 1, 0);
        if (a_n < 4) a_got[a_n] = a_byte;
        a_n++;
      end
      if (b_valid) begin
        if (b_n < 4) b_got[b_n] = b_byte;
        b_n++;
      end
      if (lh[1] == line_in && lh[0] == line_in)
        chk(a_rclk == (a_bit ^ line_in), "R5 recovered clock", a_rclk, a_bit ^ line_in);
    end
    a_prev_v = a_valid;
    lh = {lh[1:0], line_in};
  end

  task automatic do_reset();
    rst_n = 1'b0;
    line_in = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    a_n = 0;
    b_n = 0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b, input int half);
    line_in = b;
    repeat (half) @(posedge clk);
    #1 line_in = ~b;
    repeat (half) @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input logic lead, input logic [15:0] d, input int nb, input int half);
    send_bit(lead, half);
    for (int i = nb - 1; i >= 0; i--) send_bit(d[i], half);
    line_in = 1'b0;
    repeat (4 * half) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk(a_bit == 0 && b_bit == 0, "R10 bit_out after reset", a_bit, 0);
    chk(a_rclk == 0 && b_rclk == 0, "R10 rec_clk after reset", a_rclk, 0);
    chk(a_byte == 0 && b_byte == 0, "R10 byte_out after reset", a_byte, 0);
    chk(a_valid == 0 && b_valid == 0, "R10 byte_valid after reset", a_valid, 0);
  endtask

  task automatic t_latency(input bit slow);
    int n = 0;
    do_reset();
    line_in = 1'b1;
    while (((slow ? b_bit : a_bit) == 1'b0) && n < 40) begin
      @(posedge clk);
      #1 n++;
    end
    chk(n == (slow ? B_DLY : A_DLY) + 3, slow ? "R2 R1 latency slow" : "R2 R1 latency",
        n, (slow ? B_DLY : A_DLY) + 3);
  endtask

  task automatic t_single();
    do_reset();
    send_frame(1'b0, 16'h0034, 8, A_BIT / 2);
    chk(a_n == 1, "R6 byte count", a_n, 1);
    chk(a_got[0] == 8'h34, "R6 R4 byte 0x34", a_got[0], 8'h34);
    chk(a_byte == 8'h34, "R7 byte_out holds", a_byte, 8'h34);
  endtask

  task automatic t_two_bytes(input logic [15:0] d);
    do_reset();
    send_frame(1'b0, d, 16, A_BIT / 2);
    chk(a_n == 2, "R7 two strobes", a_n, 2);
    chk(a_got[0] == d[15:8], "R7 R3 first byte", a_got[0], d[15:8]);
    chk(a_got[1] == d[7:0], "R7 R3 second byte", a_got[1], d[7:0]);
  endtask

  task automatic t_complement();
    do_reset();
    send_frame(1'b1, 16'h00ff, 8, A_BIT / 2);
    chk(a_n == 1, "R8 byte count", a_n, 1);
    chk(a_got[0] == 8'h00, "R8 complement byte", a_got[0], 8'h00);
  endtask

  task automatic t_coincide();
    do_reset();
    line_in = 1'b1;
    repeat (A_DLY) @(posedge clk);
    #1 line_in = 1'b0;
    repeat (5) @(posedge clk);
    #1 line_in = 1'b1;
    repeat (2 * A_DLY + 2 - A_DLY - 5) @(posedge clk);
    #1 chk(a_bit == 1'b0, "R9 before restarted sample", a_bit, 0);
    @(posedge clk);
    #1 chk(a_bit == 1'b1, "R9 restarted sample", a_bit, 1);
  endtask

  task automatic t_slow();
    do_reset();
    send_frame(1'b0, 16'h00c9, 8, B_BIT / 2);
    chk(b_n == 1, "R2 slow byte count", b_n, 1);
    chk(b_got[0] == 8'hc9, "R2 R6 slow byte", b_got[0], 8'hc9);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_latency(1'b0);
    t_latency(1'b1);
    t_single();
    t_two_bytes(16'ha53c);
    t_two_bytes(16'h00ff);
    t_two_bytes(16'h55aa);
    t_complement();
    t_coincide();
    t_slow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule